// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date in packed BCD. A free-running base clock enable, nominally 32768 Hz, is divided down to a one-second strobe. Each strobe advances the seconds. Carries ripple on through minutes, hours, day of week, day of month, month and a three-digit year. Month lengths follow the calendar, and February gains a day in leap years.

Software sets any field by presenting a field code and a BCD value on a single-cycle write port. All seven fields and the one-second strobe are driven continuously as outputs. A separate alarm unit can therefore compare against them without a read path. A global run enable gates both the divider and every write. Raising it starts a fresh full second, and dropping it freezes the time.

Top module: `bcd_calendar`

## Requirements
- R1: While counting, `sec_pulse` is high for exactly one cycle. It goes high in the cycle after the SEC_DIV-th counted enable. A counted enable is a cycle with `tick_en` high and `run_en` high both in that cycle and in the cycle before. The divider then reloads a full second.
- R2: In the first cycle `run_en` is high after being low, the divider loads a full SEC_DIV count, and a `tick_en` in that cycle is not counted. While `run_en` is low, no pulse occurs and the count is frozen. Re-enabling after a partial second starts again from a full second.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and produce a day carry. The new values appear in the same cycle that `sec_pulse` is high.
- R4: Each day carry advances `bcd_wday`, which counts 0 to 6 and wraps to 0.
- R5: On a day carry, the day of month wraps to 01 after the month's last day and carries into the month. Months 04, 06, 09 and 11 have 30 days, month 02 has 28, and the rest have 31.
- R6: The month counts 01 to 12 in BCD. On a carry out of 12 it wraps to 01 and increments the year.
- R7: The year is three BCD digits: tens and units in bits [7:0], hundreds in bits [11:8]. It counts 000 to 999 and wraps to 000.
- R8: February has 29 days when the year is divisible by 4 and either not divisible by 100 or divisible by 400, with year 000 counted as divisible by 400. So 000, 004 and 400 are leap years and 100 is not.
- R9: A write with `wr_en` high takes effect in the next cycle, and only if `run_en` is high in the write cycle. Otherwise it is ignored. The `wr_sel` codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year; code 7 changes nothing.
- R10: A write in the same cycle as a one-second step sets the written field to the written value. Every other field still advances as usual.
- R11: After reset the time reads 000-01-01, day of week 0, 00:00:00, with `sec_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base clock enable, one per base period |
| run_en | input | 1 | Global enable for counting and writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field code of the write |
| wr_data | input | 12 | BCD value to write |
| sec_pulse | output | 1 | One-cycle strobe when the time advances |
| bcd_sec | output | 7 | Seconds, BCD |
| bcd_min | output | 7 | Minutes, BCD |
| bcd_hour | output | 6 | Hours, BCD |
| bcd_wday | output | 3 | Day of week 0 to 6 |
| bcd_mday | output | 6 | Day of month, BCD |
| bcd_mon | output | 5 | Month 01 to 12, BCD |
| bcd_year | output | 12 | Year, three BCD digits |

## Verification
The assertions watch a set of properties on every cycle:
- a pulse only follows a cycle with the run enable high, and it never lasts two cycles;
- no field moves while the run enable is low;
- minutes hold when the seconds did not wrap;
- a step keeps the day of week and day of month inside their ranges;
- the last second of year 999 rolls to 000.

Other behaviour is only visible in the bench's scenarios, because it depends on the calendar and on precise timing:
- the exact SEC_DIV count to a pulse, after both a cold start and a restart;
- month lengths and the leap rule across the century years;
- a write racing a step.

A randomized stretch with bursty enables, run toggles and writes is compared each cycle against a binary-arithmetic calendar model.

// File: rtl/bcdcal_pkg.sv
// Shared widths, field codes, the time record and BCD increment helpers.
package bcdcal_pkg;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int MDAY_W = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 12;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } field_e;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [MDAY_W-1:0] mday;
        logic [WDAY_W-1:0] wday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    // Two-digit BCD increment; the caller handles the wrap.
    function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = v[7:4];
        lo = v[3:0];
        if (lo >= 4'd9) begin
            hi = hi + 4'd1;
            lo = 4'd0;
        end else begin
            lo = lo + 4'd1;
        end
        return {hi, lo};
    endfunction

    // Three-digit BCD increment, 999 wraps to 000.
    function automatic logic [11:0] bcd3_inc(input logic [11:0] v);
        logic [3:0] hund;
        hund = v[11:8];
        if (v[7:0] >= 8'h99) begin
            hund = (hund >= 4'd9) ? 4'd0 : hund + 4'd1;
            return {hund, 8'h00};
        end
        return {hund, bcd2_inc(v[7:0])};
    endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
// Divides the base clock enable down to a one-second step.
// Assumes tick_en is a single-cycle qualifier; a rising run_en reloads a
// full second and the enable in that same cycle is not counted.
module bcdcal_prescaler #(
    parameter int SEC_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick_en,
    output logic step,
    output logic pulse
);

    localparam int CNT_W = $clog2(SEC_DIV + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SEC_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             counting;

    assign counting = run_en && run_q && tick_en;
    assign step     = counting && (cnt_q == LAST);

    // Countdown of counted enables, reload on enable rise or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
            run_q <= 1'b0;
            pulse <= 1'b0;
        end else begin
            run_q <= run_en;
            pulse <= step;
            if (run_en && !run_q) begin
                cnt_q <= FULL;
            end else if (counting) begin
                cnt_q <= (cnt_q == LAST) ? FULL : cnt_q - LAST;
            end
        end
    end

endmodule

// File: rtl/bcdcal_month_len.sv
// Length of the current month in BCD, with the leap rule evaluated
// directly on the three BCD year digits (000 counts as a 400 multiple).
// Assumes valid BCD; a month outside 01..12 is treated as 31 days.
module bcdcal_month_len
    import bcdcal_pkg::*;
(
    input  logic [MON_W-1:0]  mon,
    input  logic [YEAR_W-1:0] year,
    output logic [MDAY_W-1:0] days
);

    logic [4:0] low_mod;
    logic       by4;
    logic       by100;
    logic       by400;
    logic       leap;

    // A two-digit BCD value 10*T+U is a multiple of 4 when 2*T+U is.
    always_comb begin
        low_mod = {year[7:4], 1'b0} + {1'b0, year[3:0]};
        by4     = (low_mod[1:0] == 2'b00);
        by100   = (year[7:0] == 8'h00);
        by400   = by100 && (year[9:8] == 2'b00);
        leap    = by4 && (!by100 || by400);
    end

    // Month length lookup.
    always_comb begin
        unique case (mon)
            5'h02:                      days = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: days = 6'h30;
            default:                    days = 6'h31;
        endcase
    end

endmodule

// File: rtl/bcdcal_timekeeper.sv
// Holds the calendar fields and advances them on a step with the full
// carry chain; a qualified write overrides only the field it selects.
// Assumes the month length input reflects the currently held month/year.
module bcdcal_timekeeper
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_fire,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [11:0]       wr_data,
    input  logic [MDAY_W-1:0] month_days,
    output cal_t              cal_q
);

    cal_t cal_nx;
    logic c_min;
    logic c_hour;
    logic c_day;
    logic c_mon;
    logic c_year;

    // Carry chain, each stage from the pre-step value.
    always_comb begin
        c_min  = step   && (cal_q.sec  >= 7'h59);
        c_hour = c_min  && (cal_q.min  >= 7'h59);
        c_day  = c_hour && (cal_q.hour >= 6'h23);
        c_mon  = c_day  && (cal_q.mday >= month_days);
        c_year = c_mon  && (cal_q.mon  >= 5'h12);
    end

    // Next-state: increments first, then the write override.
    always_comb begin
        cal_nx = cal_q;
        if (step) begin
            cal_nx.sec = c_min ? '0 : SEC_W'(bcd2_inc(8'(cal_q.sec)));
        end
        if (c_min) begin
            cal_nx.min = c_hour ? '0 : MIN_W'(bcd2_inc(8'(cal_q.min)));
        end
        if (c_hour) begin
            cal_nx.hour = c_day ? '0 : HOUR_W'(bcd2_inc(8'(cal_q.hour)));
        end
        if (c_day) begin
            cal_nx.wday = (cal_q.wday >= 3'd6) ? '0 : cal_q.wday + 3'd1;
            cal_nx.mday = c_mon ? 6'h01 : MDAY_W'(bcd2_inc(8'(cal_q.mday)));
        end
        if (c_mon) begin
            cal_nx.mon = c_year ? 5'h01 : MON_W'(bcd2_inc(8'(cal_q.mon)));
        end
        if (c_year) begin
            cal_nx.year = bcd3_inc(cal_q.year);
        end
        if (wr_fire) begin
            unique case (field_e'(wr_sel))
                FLD_SEC:  cal_nx.sec  = wr_data[SEC_W-1:0];
                FLD_MIN:  cal_nx.min  = wr_data[MIN_W-1:0];
                FLD_HOUR: cal_nx.hour = wr_data[HOUR_W-1:0];
                FLD_WDAY: cal_nx.wday = wr_data[WDAY_W-1:0];
                FLD_MDAY: cal_nx.mday = wr_data[MDAY_W-1:0];
                FLD_MON:  cal_nx.mon  = wr_data[MON_W-1:0];
                FLD_YEAR: cal_nx.year = wr_data[YEAR_W-1:0];
                FLD_NONE: ;
            endcase
        end
    end

    // Field registers with reset to 000-01-01 00:00:00.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q      <= '0;
            cal_q.mday <= 6'h01;
            cal_q.mon  <= 5'h01;
        end else begin
            cal_q <= cal_nx;
        end
    end

endmodule

// File: rtl/bcd_calendar.sv
// Top of the BCD calendar: divider, month-length decode and field store.
// Assumes writes carry valid BCD; run_en gates counting and all writes.
module bcd_calendar
    import bcdcal_pkg::*;
#(
    parameter int SEC_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [11:0]       wr_data,
    output logic              sec_pulse,
    output logic [SEC_W-1:0]  bcd_sec,
    output logic [MIN_W-1:0]  bcd_min,
    output logic [HOUR_W-1:0] bcd_hour,
    output logic [WDAY_W-1:0] bcd_wday,
    output logic [MDAY_W-1:0] bcd_mday,
    output logic [MON_W-1:0]  bcd_mon,
    output logic [YEAR_W-1:0] bcd_year
);

    logic              step;
    logic              wr_fire;
    logic [MDAY_W-1:0] month_days;
    cal_t              cal;

    assign wr_fire = wr_en && run_en;

    bcdcal_prescaler #(.SEC_DIV(SEC_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .tick_en (tick_en),
        .step    (step),
        .pulse   (sec_pulse)
    );

    bcdcal_month_len u_mlen (
        .mon  (cal.mon),
        .year (cal.year),
        .days (month_days)
    );

    bcdcal_timekeeper u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .wr_fire    (wr_fire),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .month_days (month_days),
        .cal_q      (cal)
    );

    assign bcd_sec  = cal.sec;
    assign bcd_min  = cal.min;
    assign bcd_hour = cal.hour;
    assign bcd_wday = cal.wday;
    assign bcd_mday = cal.mday;
    assign bcd_mon  = cal.mon;
    assign bcd_year = cal.year;

endmodule

// File: rtl/bcdcal_checker.sv
// Cycle-level properties of the calendar ports; bound into the top.
module bcdcal_checker
    import bcdcal_pkg::*;
#(
    parameter int SEC_DIV = 32768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              wr_en,
    input logic              sec_pulse,
    input logic [SEC_W-1:0]  bcd_sec,
    input logic [MIN_W-1:0]  bcd_min,
    input logic [HOUR_W-1:0] bcd_hour,
    input logic [WDAY_W-1:0] bcd_wday,
    input logic [MDAY_W-1:0] bcd_mday,
    input logic [MON_W-1:0]  bcd_mon,
    input logic [YEAR_W-1:0] bcd_year
);

    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(run_en)); // R2

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_DIV > 1) && sec_pulse |=> !sec_pulse); // R1

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(run_en) |-> $stable(bcd_sec) && $stable(bcd_min)
        && $stable(bcd_hour) && $stable(bcd_wday) && $stable(bcd_mday)
        && $stable(bcd_mon) && $stable(bcd_year)); // R9

    AST_MIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse && $past(rst_n) && !$past(wr_en) && ($past(bcd_sec) != 7'h59)
        |-> bcd_min == $past(bcd_min)); // R3

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse && $past(rst_n) && !$past(wr_en) && ($past(bcd_wday) <= 3'd6)
        |-> bcd_wday <= 3'd6); // R4

    AST_MDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse && $past(rst_n) && !$past(wr_en) && ($past(bcd_mday) != 6'h00)
        |-> bcd_mday != 6'h00); // R5

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse && $past(rst_n) && !$past(wr_en) && ($past(bcd_year) == 12'h999)
        && ($past(bcd_mon) == 5'h12) && ($past(bcd_mday) == 6'h31)
        && ($past(bcd_hour) == 6'h23) && ($past(bcd_min) == 7'h59)
        && ($past(bcd_sec) == 7'h59)
        |-> bcd_year == 12'h000); // R7

endmodule

bind bcd_calendar bcdcal_checker #(.SEC_DIV(SEC_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .wr_en     (wr_en),
    .sec_pulse (sec_pulse),
    .bcd_sec   (bcd_sec),
    .bcd_min   (bcd_min),
    .bcd_hour  (bcd_hour),
    .bcd_wday  (bcd_wday),
    .bcd_mday  (bcd_mday),
    .bcd_mon   (bcd_mon),
    .bcd_year  (bcd_year)
);

// File: tb/bcd_calendar_tb.sv
// Bench: directed corners plus seeded random stimulus, compared every
// cycle against a binary-arithmetic calendar model.
module bcd_calendar_tb;

    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [11:0] wr_data = 12'd0;
    logic        sec_pulse;
    logic [6:0]  bcd_sec;
    logic [6:0]  bcd_min;
    logic [5:0]  bcd_hour;
    logic [2:0]  bcd_wday;
    logic [5:0]  bcd_mday;
    logic [4:0]  bcd_mon;
    logic [11:0] bcd_year;

    int total = 0;
    int failed = 0;
    bit done = 0;

    bcd_calendar #(.SEC_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_pulse(sec_pulse), .bcd_sec(bcd_sec), .bcd_min(bcd_min),
        .bcd_hour(bcd_hour), .bcd_wday(bcd_wday), .bcd_mday(bcd_mday),
        .bcd_mon(bcd_mon), .bcd_year(bcd_year)
    );

    always #4 clk = ~clk;

    function automatic int bin2bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction
    function automatic int year2bcd(int v);
        return ((v / 100) << 8) | bin2bcd(v % 100);
    endfunction
    function automatic int bcd2bin(int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction
    function automatic int mlen(int m, int y);
        bit leap;
        leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // Reference model state, binary values.
    int m_cnt, m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;
    bit m_runq, m_pulse;

    always @(posedge clk) begin
        bit stp;
        int s, mi, h, wd, md, mo, y;
        if (!rst_n) begin
            m_cnt = DIV; m_runq = 0; m_pulse = 0;
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0;
            m_mday = 1; m_mon = 1; m_year = 0;
        end else begin
            stp = run_en && m_runq && tick_en && (m_cnt == 1);
            if (run_en && !m_runq) m_cnt = DIV;
            else if (run_en && m_runq && tick_en) m_cnt = (m_cnt == 1) ? DIV : m_cnt - 1;
            m_runq = run_en;
            s = m_sec; mi = m_min; h = m_hour; wd = m_wday;
            md = m_mday; mo = m_mon; y = m_year;
            if (stp) begin
                s = s + 1;
                if (s >= 60) begin
                    s = 0; mi = mi + 1;
                    if (mi >= 60) begin
                        mi = 0; h = h + 1;
                        if (h >= 24) begin
                            h = 0;
                            wd = (wd >= 6) ? 0 : wd + 1;
                            if (md >= mlen(m_mon, m_year)) begin
                                md = 1; mo = mo + 1;
                                if (mo > 12) begin
                                    mo = 1;
                                    y = (y >= 999) ? 0 : y + 1;
                                end
                            end else md = md + 1;
                        end
                    end
                end
            end
            if (wr_en && run_en) begin
                case (wr_sel)
                    3'd0: s  = bcd2bin(int'(wr_data[6:0]));
                    3'd1: mi = bcd2bin(int'(wr_data[6:0]));
                    3'd2: h  = bcd2bin(int'(wr_data[5:0]));
                    3'd3: wd = int'(wr_data[2:0]);
                    3'd4: md = bcd2bin(int'(wr_data[5:0]));
                    3'd5: mo = bcd2bin(int'(wr_data[4:0]));
                    3'd6: y  = bcd2bin(int'(wr_data[7:0])) + 100 * int'(wr_data[11:8]);
                    default: ;
                endcase
            end
            m_sec = s; m_min = mi; m_hour = h; m_wday = wd;
            m_mday = md; m_mon = mo; m_year = y;
            m_pulse = stp;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        check("R1", "pulse", int'(sec_pulse), int'(m_pulse));
        check("R3", "sec",   int'(bcd_sec),   bin2bcd(m_sec));
        check("R3", "min",   int'(bcd_min),   bin2bcd(m_min));
        check("R3", "hour",  int'(bcd_hour),  bin2bcd(m_hour));
        check("R4", "wday",  int'(bcd_wday),  m_wday);
        check("R5", "mday",  int'(bcd_mday),  bin2bcd(m_mday));
        check("R6", "mon",   int'(bcd_mon),   bin2bcd(m_mon));
        check("R7", "year",  int'(bcd_year),  year2bcd(m_year));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(int sel, int val);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 12'(val);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic set_time(int y, int mo, int md, int wd, int h, int mi, int s);
        tick_en = 1'b0; run_en = 1'b1;
        wr(6, year2bcd(y)); wr(5, bin2bcd(mo)); wr(4, bin2bcd(md));
        wr(3, wd); wr(2, bin2bcd(h)); wr(1, bin2bcd(mi)); wr(0, bin2bcd(s));
        tick_en = 1'b1;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            cyc();
            n++;
        end while (!sec_pulse && n < 100);
    endtask

    task automatic feb_case(int y, int exp_md, int exp_mo);
        int n;
        set_time(y, 2, 28, 1, 23, 59, 59);
        wait_pulse(n);
        check("R8", "feb28 mday", int'(bcd_mday), exp_md);
        check("R8", "feb28 mon",  int'(bcd_mon),  exp_mo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", total, failed);
            $finish;
        end
    end

    initial begin
        int n;
        int sel, v;
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        // R11 reset state
        check("R11", "rst sec",  int'(bcd_sec), 0);
        check("R11", "rst mday", int'(bcd_mday), 8'h01);
        check("R11", "rst mon",  int'(bcd_mon), 8'h01);
        check("R11", "rst year", int'(bcd_year), 0);
        check("R11", "rst pulse", int'(sec_pulse), 0);
        rst_n = 1'b1;
        cyc();

        // R2/R1: cold start needs DIV counted enables after the load cycle
        run_en = 1'b1; tick_en = 1'b1;
        wait_pulse(n);
        check("R2", "cycles to first pulse", n, DIV + 1);
        wait_pulse(n);
        check("R1", "pulse period", n, DIV);
        repeat (3) cyc();
        run_en = 1'b0;
        n = 0;
        repeat (40) begin
            cyc();
            if (sec_pulse) n++;
        end
        check("R2", "pulses while stopped", n, 0);
        run_en = 1'b1;
        wait_pulse(n);
        check("R2", "restart full second", n, DIV + 1);

        // R3..R7 full rollover
        set_time(999, 12, 31, 6, 23, 59, 59);
        wait_pulse(n);
        check("R7", "year wrap", int'(bcd_year), 0);
        check("R6", "month wrap", int'(bcd_mon), 8'h01);
        check("R5", "mday wrap", int'(bcd_mday), 8'h01);
        check("R4", "wday wrap", int'(bcd_wday), 0);
        check("R3", "hms wrap", int'({bcd_hour, bcd_min, bcd_sec}), 0);

        // R8 leap corners
        feb_case(4, 8'h29, 8'h02);
        feb_case(100, 8'h01, 8'h03);
        feb_case(0, 8'h29, 8'h02);
        feb_case(400, 8'h29, 8'h02);
        feb_case(7, 8'h01, 8'h03);
        set_time(4, 2, 29, 1, 23, 59, 59);
        wait_pulse(n);
        check("R8", "feb29 to mar", int'(bcd_mon), 8'h03);

        // R5 30-day month, R3 hour carry without day carry
        set_time(123, 4, 30, 2, 23, 59, 59);
        wait_pulse(n);
        check("R5", "apr30 next", int'({bcd_mon, bcd_mday}), {5'h05, 6'h01});
        check("R4", "wday step", int'(bcd_wday), 3);
        set_time(123, 5, 10, 2, 10, 59, 59);
        wait_pulse(n);
        check("R3", "hour carry", int'(bcd_hour), 8'h11);
        check("R5", "no day carry", int'(bcd_mday), 8'h10);

        // R9 writes ignored while stopped, and code 7 changes nothing
        run_en = 1'b0;
        cyc();
        v = int'(bcd_sec);
        wr(0, 8'h33);
        check("R9", "sec write while off", int'(bcd_sec), v);
        wr(6, 12'h555);
        check("R9", "year write while off", int'(bcd_year), 12'h123);
        run_en = 1'b1; tick_en = 1'b0;
        cyc();
        v = int'({bcd_year, bcd_mon, bcd_mday, bcd_hour, bcd_min, bcd_sec});
        wr(7, 12'h777);
        check("R9", "code 7 no change",
              int'({bcd_year, bcd_mon, bcd_mday, bcd_hour, bcd_min, bcd_sec}), v);

        // R10 write racing the step
        set_time(50, 6, 15, 3, 8, 5, 10);
        while (!(m_runq && m_cnt == 1)) cyc();
        wr(1, 8'h20);
        check("R10", "pulse on race", int'(sec_pulse), 1);
        check("R10", "sec advanced", int'(bcd_sec), 8'h11);
        check("R10", "min written", int'(bcd_min), 8'h20);
        while (!(m_runq && m_cnt == 1)) cyc();
        wr(0, 8'h45);
        check("R10", "sec write wins", int'(bcd_sec), 8'h45);

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            tick_en = ($urandom % 4) != 0;
            if ($urandom % 300 == 0) run_en = ~run_en;
            wr_en = ($urandom % 12) == 0;
            sel = int'($urandom % 8);
            case (sel)
                0, 1: v = ($urandom % 2) ? 59 : int'($urandom % 60);
                2:    v = ($urandom % 2) ? 23 : int'($urandom % 24);
                3:    v = int'($urandom % 7);
                4:    v = ($urandom % 2) ? 28 : 1 + int'($urandom % 28);
                5:    v = ($urandom % 2) ? 12 : 1 + int'($urandom % 12);
                6:    v = ($urandom % 2) ? 999 : int'($urandom % 1000);
                default: v = int'($urandom % 100);
            endcase
            wr_sel = 3'(sel);
            wr_data = (sel == 6) ? 12'(year2bcd(v)) : (sel == 3) ? 12'(v) : 12'(bin2bcd(v));
            cyc();
        end
        wr_en = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end

endmodule